// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block supervises the erase of one region of an on-chip flash array. Software first loads a control register (erase enable, a two-bit region size, a pump divider select and a high-voltage request bit), then writes to any address inside the region to be erased. That write captures the address, aligned to the chosen region size, as the erase target. When software then raises the high-voltage request, the sequencer checks three things: a target is held, the target does not reach into the protected area, and the bus clock is fast enough. Only if all three hold does it assert the high-voltage enable toward the array.

While high voltage is applied, a pump clock enable is produced from the bus clock. It pulses on every bus cycle, or on every second bus cycle when the divider select is set. An erase timer counts these pump pulses up to a parameterised erase length, then removes high voltage and reports completion. Software ends every attempt by clearing the request bit. Dropping the request or the erase bit early aborts the erase. Losing the bus clock aborts it with an error.

The controller has four states. IDLE waits for a request. ERASING applies high voltage and counts. DONE holds completion with high voltage off. FAULT reports a refused or broken attempt. The transitions are: IDLE→ERASING on a request rise with every check passing (start). IDLE→FAULT on a request rise with any check failing (refuse). ERASING→IDLE when the request or erase bit drops (abort). ERASING→FAULT when the bus clock is lost (clock loss). ERASING→DONE when the timer expires (expire). DONE→IDLE and FAULT→IDLE when the request bit is cleared (release). Abort takes priority over clock loss, and clock loss takes priority over expire.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, `hv_en`, `busy`, `done`, `err`, `tgt_vld` and `pump_tick` are all 0.
- R2: In IDLE with `ctl_erase`=1, a pulse on `arr_we` captures `arr_addr` ANDed with a region mask, sets `tgt_vld`, and outputs the mask on `tgt_mask`. The mask keeps the top k address bits: `ctl_blk`=00 (whole array) k=0, 01 (half) k=1, 10 (quarter) k=2, 11 (page) k=AW-PAGE_AW. With AW=12 and PAGE_AW=6 the masks are 0x000, 0x800, 0xC00 and 0xFC0. While `ctl_erase`=0 the target is cleared and writes capture nothing.
- R3: A 0→1 change of `ctl_hven` in IDLE starts an erase only when all of these hold: `tgt_vld`=1, `ctl_erase`=1, the target is unprotected, and `bus_clk_ok`=1. `hv_en` and `busy` are then 1 from the next cycle.
- R4: `hv_en` stays high for exactly ERASE_TICKS pump pulses. `pump_tick` pulses every bus cycle when `ctl_fdiv`=0 and every second bus cycle when `ctl_fdiv`=1, so `hv_en` lasts ERASE_TICKS or 2×ERASE_TICKS bus cycles.
- R5: When the timer expires, `hv_en` falls and `done` and `busy` become 1. They stay at 1 until `ctl_hven` is cleared. After that all three are 0 and the target is cleared.
- R6: A refused start sets `err`=1 and never asserts `hv_en`. `err` stays at 1 until `ctl_hven` is cleared. The held target is kept.
- R7: For a protect value P, P of all ones protects nothing. Otherwise a region is protected when its last address (target OR NOT mask) is at or above P shifted left by AW-PROT_W.
- R8: If `ctl_hven` or `ctl_erase` falls during ERASING, `hv_en` and `busy` are 0 on the next cycle. The target is cleared, and neither `done` nor `err` is raised. This abort wins over a timer expiry in the same cycle.
- R9: If `bus_clk_ok` falls during ERASING, `hv_en` is 0 on the next cycle, `err` becomes 1 and the target is cleared.
- R10: Writes on `arr_we` outside IDLE leave `tgt_addr` and `tgt_mask` unchanged.
- R11: `pump_tick` is 0 in every state other than ERASING.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_erase | input | 1 | Control register: erase enable |
| ctl_blk | input | 2 | Control register: region size select |
| ctl_fdiv | input | 1 | Control register: pump divide-by-two select |
| ctl_hven | input | 1 | Control register: high-voltage request |
| arr_we | input | 1 | Write strobe into the flash address range |
| arr_addr | input | AW | Address of that write |
| prot_val | input | PROT_W | Contents of the block-protect register |
| bus_clk_ok | input | 1 | Bus clock is at or above the minimum rate |
| pump_tick | output | 1 | Charge-pump clock enable |
| hv_en | output | 1 | High-voltage enable to the array |
| tgt_addr | output | AW | Aligned erase target address |
| tgt_mask | output | AW | Region mask of the target |
| tgt_vld | output | 1 | A target is held |
| busy | output | 1 | Erase running or completed and not yet released |
| done | output | 1 | Erase time completed |
| err | output | 1 | Start refused or erase broken by clock loss |

## Verification
Timer expiry and a software abort can land on the same clock edge. In that case the controller must take the abort and raise no completion. The bench raises the request and then drops it so that the edge that would expire the timer is the first edge to see it low. It expects `done`=0, `hv_en`=0 and an empty target one cycle later. A companion run drops the request one edge later and expects `done`=1, which confirms that the race was hit on the exact cycle.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ERASING = 2'd1,
        ST_DONE    = 2'd2,
        ST_FAULT   = 2'd3
    } fes_state_e;

    typedef enum logic [1:0] {
        BLK_FULL    = 2'b00,
        BLK_HALF    = 2'b01,
        BLK_QUARTER = 2'b10,
        BLK_PAGE    = 2'b11
    } blk_size_e;

endpackage

// File: rtl/fes_pump_div.sv
module fes_pump_div #(
    parameter int MAX_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fdiv,
    output logic tick
);
    localparam int PW = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [PW-1:0] phase;
    logic [PW-1:0] last_ph;

    always_comb begin
        last_ph = fdiv ? PW'(MAX_DIV - 1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (!run) begin
            phase <= '0;
        end else if (phase == last_ph) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    always_comb begin
        tick = run && (phase == last_ph);
    end

    AST_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && fdiv && tick) |=> (!tick || !fdiv)); // R4

endmodule

// File: rtl/fes_erase_timer.sv
module fes_erase_timer #(
    parameter int ERASE_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int CW = $clog2(ERASE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(ERASE_TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        expire = run && tick && (cnt == LAST);
    end

    AST_EXPIRE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !run); // R5

endmodule

// File: rtl/fes_tgt_latch.sv
module fes_tgt_latch
    import fes_pkg::*;
#(
    parameter int AW      = 12,
    parameter int PAGE_AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clr,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    blk,
    output logic [AW-1:0] tgt_addr,
    output logic [AW-1:0] tgt_mask,
    output logic          tgt_vld
);
    localparam int PAGE_KEEP = AW - PAGE_AW;
    localparam logic [AW-1:0] ONES = '1;

    logic [AW-1:0] new_mask;

    always_comb begin
        unique case (blk_size_e'(blk))
            BLK_FULL:    new_mask = '0;
            BLK_HALF:    new_mask = ~(ONES >> 1);
            BLK_QUARTER: new_mask = ~(ONES >> 2);
            BLK_PAGE:    new_mask = ~(ONES >> PAGE_KEEP);
            default:     new_mask = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_addr <= '0;
            tgt_mask <= '0;
            tgt_vld  <= 1'b0;
        end else if (clr) begin
            tgt_addr <= '0;
            tgt_mask <= '0;
            tgt_vld  <= 1'b0;
        end else if (load) begin
            tgt_addr <= addr & new_mask;
            tgt_mask <= new_mask;
            tgt_vld  <= 1'b1;
        end
    end

    AST_TGT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> ($stable(tgt_addr) && $stable(tgt_mask))); // R10

endmodule

// File: rtl/fes_prot_chk.sv
module fes_prot_chk #(
    parameter int AW     = 12,
    parameter int PROT_W = 8
) (
    input  logic [AW-1:0]     tgt_addr,
    input  logic [AW-1:0]     tgt_mask,
    input  logic [PROT_W-1:0] prot_val,
    output logic              tgt_prot
);
    localparam int LOW = AW - PROT_W;

    logic [AW-1:0] last_addr;
    logic [AW-1:0] boundary;
    logic          prot_off;

    always_comb begin
        last_addr = tgt_addr | ~tgt_mask;
        boundary  = AW'(prot_val) << LOW;
        prot_off  = (prot_val == '1);
        tgt_prot  = !prot_off && (last_addr >= boundary);
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int AW          = 12,
    parameter int PAGE_AW     = 6,
    parameter int PROT_W      = 8,
    parameter int ERASE_TICKS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_erase,
    input  logic [1:0]        ctl_blk,
    input  logic              ctl_fdiv,
    input  logic              ctl_hven,
    input  logic              arr_we,
    input  logic [AW-1:0]     arr_addr,
    input  logic [PROT_W-1:0] prot_val,
    input  logic              bus_clk_ok,
    output logic              pump_tick,
    output logic              hv_en,
    output logic [AW-1:0]     tgt_addr,
    output logic [AW-1:0]     tgt_mask,
    output logic              tgt_vld,
    output logic              busy,
    output logic              done,
    output logic              err
);
    localparam int PUMP_MAX_DIV = 2;

    fes_state_e state_q, state_nx;
    logic       hven_q;
    logic       hven_rise;
    logic       start_ok;
    logic       tgt_prot;
    logic       run;
    logic       expire;
    logic       latch_load;
    logic       latch_clr;
    logic       leave_active;

    // request edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hven_q <= 1'b0;
        end else begin
            hven_q <= ctl_hven;
        end
    end

    always_comb begin
        hven_rise = ctl_hven && !hven_q;
        start_ok  = tgt_vld && ctl_erase && !tgt_prot && bus_clk_ok;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hven_rise) begin
                    state_nx = start_ok ? ST_ERASING : ST_FAULT;
                end
            end
            ST_ERASING: begin
                if (!ctl_hven || !ctl_erase) begin
                    state_nx = ST_IDLE;
                end else if (!bus_clk_ok) begin
                    state_nx = ST_FAULT;
                end else if (expire) begin
                    state_nx = ST_DONE;
                end
            end
            ST_DONE: begin
                if (!ctl_hven) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_FAULT: begin
                if (!ctl_hven) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // outputs
    always_comb begin
        hv_en = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        err   = 1'b0;
        run   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ERASING: begin
                hv_en = 1'b1;
                busy  = 1'b1;
                run   = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            ST_FAULT: begin
                err = 1'b1;
            end
            default: ;
        endcase
    end

    // target capture control
    always_comb begin
        leave_active = ((state_q == ST_ERASING) || (state_q == ST_DONE)) &&
                       ((state_nx == ST_IDLE) || (state_nx == ST_FAULT));
        latch_clr    = !ctl_erase || leave_active;
        latch_load   = arr_we && ctl_erase && (state_q == ST_IDLE);
    end

    fes_tgt_latch #(
        .AW      (AW),
        .PAGE_AW (PAGE_AW)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (latch_load),
        .clr      (latch_clr),
        .addr     (arr_addr),
        .blk      (ctl_blk),
        .tgt_addr (tgt_addr),
        .tgt_mask (tgt_mask),
        .tgt_vld  (tgt_vld)
    );

    fes_prot_chk #(
        .AW     (AW),
        .PROT_W (PROT_W)
    ) u_prot (
        .tgt_addr (tgt_addr),
        .tgt_mask (tgt_mask),
        .prot_val (prot_val),
        .tgt_prot (tgt_prot)
    );

    fes_pump_div #(
        .MAX_DIV (PUMP_MAX_DIV)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .fdiv  (ctl_fdiv),
        .tick  (pump_tick)
    );

    fes_erase_timer #(
        .ERASE_TICKS (ERASE_TICKS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (pump_tick),
        .expire (expire)
    );

    AST_HV_NEEDS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> tgt_vld); // R3
    AST_HV_GRANTED_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> $past(tgt_vld && !tgt_prot && bus_clk_ok)); // R7
    AST_NO_HV_IN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !hv_en); // R6
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!hv_en && busy)); // R5
    AST_HV_OFF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_en && !ctl_hven) |=> !hv_en); // R8
    AST_CLK_LOSS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (hv_en && ctl_hven && ctl_erase && !bus_clk_ok) |=> (err && !hv_en)); // R9
    AST_TICK_ONLY_ERASING: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_en |-> !pump_tick); // R11

endmodule

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb;
    localparam int AW = 12;
    localparam int PAGE_AW = 6;
    localparam int PROT_W = 8;
    localparam int TICKS = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_erase = 1'b0;
    logic [1:0] ctl_blk = 2'b00;
    logic ctl_fdiv = 1'b0;
    logic ctl_hven = 1'b0;
    logic arr_we = 1'b0;
    logic [AW-1:0] arr_addr = '0;
    logic [PROT_W-1:0] prot_val = '1;
    logic bus_clk_ok = 1'b1;
    logic pump_tick, hv_en, tgt_vld, busy, done, err;
    logic [AW-1:0] tgt_addr, tgt_mask;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    flash_erase_seq #(
        .AW(AW), .PAGE_AW(PAGE_AW), .PROT_W(PROT_W), .ERASE_TICKS(TICKS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_erase(ctl_erase), .ctl_blk(ctl_blk),
        .ctl_fdiv(ctl_fdiv), .ctl_hven(ctl_hven), .arr_we(arr_we),
        .arr_addr(arr_addr), .prot_val(prot_val), .bus_clk_ok(bus_clk_ok),
        .pump_tick(pump_tick), .hv_en(hv_en), .tgt_addr(tgt_addr),
        .tgt_mask(tgt_mask), .tgt_vld(tgt_vld), .busy(busy), .done(done),
        .err(err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a);
        @(negedge clk);
        arr_we = 1'b1;
        arr_addr = a;
        @(negedge clk);
        arr_we = 1'b0;
    endtask

    task automatic set_hven(input logic v);
        @(negedge clk);
        ctl_hven = v;
    endtask

    task automatic clear_target();
        @(negedge clk);
        ctl_erase = 1'b0;
        @(negedge clk);
        ctl_erase = 1'b1;
    endtask

    task automatic arm(input logic [1:0] blk, input logic [AW-1:0] a);
        ctl_blk = blk;
        ctl_erase = 1'b1;
        do_write(a);
    endtask

    task automatic release_req();
        set_hven(1'b0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "hv_en", hv_en, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "err", err, 0);
        chk("R1", "tgt_vld", tgt_vld, 0);
        chk("R1", "pump_tick", pump_tick, 0);
    endtask

    task automatic t_latch();
        arm(2'b11, 12'hABC);
        chk("R2", "page addr", tgt_addr, 32'hA80);
        chk("R2", "page mask", tgt_mask, 32'hFC0);
        chk("R2", "vld", tgt_vld, 1);
        arm(2'b00, 12'h123);
        chk("R2", "full addr", tgt_addr, 32'h000);
        chk("R2", "full mask", tgt_mask, 32'h000);
        arm(2'b01, 12'hABC);
        chk("R2", "half addr", tgt_addr, 32'h800);
        chk("R2", "half mask", tgt_mask, 32'h800);
        arm(2'b10, 12'h7BC);
        chk("R2", "quarter addr", tgt_addr, 32'h400);
        chk("R2", "quarter mask", tgt_mask, 32'hC00);
        @(negedge clk);
        ctl_erase = 1'b0;
        do_write(12'h555);
        chk("R2", "no capture with erase off", tgt_vld, 0);
        ctl_erase = 1'b1;
    endtask

    task automatic t_erase(input logic fdiv, input int exp_cycles);
        int hv_cnt = 0;
        int tk_cnt = 0;
        int bad_busy = 0;
        prot_val = '1;
        ctl_fdiv = fdiv;
        arm(2'b11, 12'h840);
        set_hven(1'b1);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (hv_en) begin
                hv_cnt++;
                if (pump_tick) tk_cnt++;
                if (!busy) bad_busy++;
            end
            if (done) break;
        end
        chk("R3", "busy during hv", bad_busy, 0);
        chk("R4", "hv cycles", hv_cnt, exp_cycles);
        chk("R4", "pump pulses", tk_cnt, TICKS);
        chk("R5", "done", done, 1);
        chk("R5", "busy at done", busy, 1);
        chk("R5", "hv off at done", hv_en, 0);
        chk("R11", "no pump in done", pump_tick, 0);
        repeat (3) @(negedge clk);
        chk("R5", "done held", done, 1);
        release_req();
        chk("R5", "done after release", done, 0);
        chk("R5", "busy after release", busy, 0);
        chk("R5", "target cleared", tgt_vld, 0);
        chk("R11", "no pump idle", pump_tick, 0);
        ctl_fdiv = 1'b0;
    endtask

    task automatic t_refuse();
        int hv_seen = 0;
        clear_target();
        set_hven(1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (hv_en) hv_seen++;
        end
        chk("R6", "err no target", err, 1);
        chk("R6", "hv never", hv_seen, 0);
        chk("R6", "busy with err", busy, 0);
        release_req();
        chk("R6", "err released", err, 0);

        prot_val = 8'hC0;
        arm(2'b11, 12'hC40);
        set_hven(1'b1);
        @(negedge clk);
        chk("R7", "protected page refused", err, 1);
        chk("R7", "hv off protected", hv_en, 0);
        chk("R6", "target kept", tgt_vld, 1);
        release_req();

        arm(2'b11, 12'hBC0);
        set_hven(1'b1);
        @(negedge clk);
        chk("R7", "page below boundary starts", hv_en, 1);
        release_req();

        arm(2'b01, 12'h900);
        set_hven(1'b1);
        @(negedge clk);
        chk("R7", "half reaching boundary refused", err, 1);
        release_req();

        prot_val = '1;
        arm(2'b11, 12'h840);
        bus_clk_ok = 1'b0;
        set_hven(1'b1);
        @(negedge clk);
        chk("R3", "slow clock refused", err, 1);
        chk("R3", "slow clock no hv", hv_en, 0);
        release_req();
        bus_clk_ok = 1'b1;
    endtask

    task automatic t_abort();
        arm(2'b11, 12'h840);
        set_hven(1'b1);
        repeat (5) @(negedge clk);
        chk("R8", "running before abort", hv_en, 1);
        ctl_hven = 1'b0;
        @(negedge clk);
        chk("R8", "hv off after request drop", hv_en, 0);
        chk("R8", "busy off", busy, 0);
        chk("R8", "no done", done, 0);
        chk("R8", "no err", err, 0);
        chk("R8", "target cleared", tgt_vld, 0);

        arm(2'b11, 12'h840);
        set_hven(1'b1);
        repeat (4) @(negedge clk);
        ctl_erase = 1'b0;
        @(negedge clk);
        chk("R8", "hv off after erase drop", hv_en, 0);
        chk("R8", "no err erase drop", err, 0);
        ctl_erase = 1'b1;
        release_req();
    endtask

    task automatic t_busloss();
        arm(2'b11, 12'h840);
        set_hven(1'b1);
        repeat (3) @(negedge clk);
        bus_clk_ok = 1'b0;
        @(negedge clk);
        chk("R9", "hv off on clock loss", hv_en, 0);
        chk("R9", "err on clock loss", err, 1);
        chk("R9", "target cleared", tgt_vld, 0);
        bus_clk_ok = 1'b1;
        release_req();
        chk("R9", "err released", err, 0);
    endtask

    task automatic t_busy_write();
        arm(2'b11, 12'h840);
        set_hven(1'b1);
        repeat (2) @(negedge clk);
        ctl_blk = 2'b00;
        do_write(12'h300);
        chk("R10", "addr frozen", tgt_addr, 32'h840);
        chk("R10", "mask frozen", tgt_mask, 32'hFC0);
        release_req();
        prot_val = 8'h00;
        arm(2'b11, 12'h840);
        set_hven(1'b1);
        @(negedge clk);
        do_write(12'h2C0);
        chk("R10", "addr frozen in fault", tgt_addr, 32'h840);
        release_req();
        prot_val = '1;
    endtask

    task automatic t_race();
        arm(2'b11, 12'h840);
        set_hven(1'b1);
        @(posedge clk);
        repeat (TICKS - 1) @(posedge clk);
        @(negedge clk);
        chk("R4", "hv on last cycle", hv_en, 1);
        ctl_hven = 1'b0;
        @(negedge clk);
        chk("R8", "race abort no done", done, 0);
        chk("R8", "race abort hv off", hv_en, 0);
        chk("R8", "race abort target cleared", tgt_vld, 0);
        @(negedge clk);

        arm(2'b11, 12'h840);
        set_hven(1'b1);
        @(posedge clk);
        repeat (TICKS) @(posedge clk);
        @(negedge clk);
        chk("R5", "one cycle later done", done, 1);
        release_req();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_latch();
        t_erase(1'b0, TICKS);
        t_erase(1'b1, 2 * TICKS);
        t_refuse();
        t_abort();
        t_busloss();
        t_busy_write();
        t_race();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule